// File: doc/BRIEF.md
# Offset Min-Sum Check Node Processor

This block produces the check-to-variable messages for a single parity check of a layered LDPC decoder. In one cycle it takes up to eight variable-to-check messages, one lane per block column of the base matrix. Each message is a 6-bit sign-magnitude value. A connect mask says which lanes take part in the current check row. For every connected lane it returns a new message. The magnitude of that message is the smallest magnitude seen on the other connected lanes, lowered by a fixed offset of one LSB and floored at zero. Its sign is the parity of the other connected lanes' signs.

Only comparators, one subtractor per lane and selectors are used. A single search keeps the smallest magnitude, the lane it came from and the runner-up magnitude. The lane that held the smallest value is given the runner-up, and every other lane is given the smallest. The result is registered once, so a row-serial scheduler can feed the outputs back on the cycle after it presents a row. A valid flag travels alongside the data.

Top module: `ms_check_node`

## Requirements
- R1: Lane i of both message buses occupies bits [6i+5:6i]. Bit 6i+5 is the sign (1 = negative) and bits [6i+4:6i] are the unsigned magnitude.
- R2: A connected lane's output magnitude is the minimum magnitude over all other connected lanes, minus 1. A value that would go below zero is floored at 0.
- R3: The lane holding the smallest magnitude receives the second-smallest magnitude, less the offset. When several lanes tie for the minimum, each of them receives that same minimum less the offset.
- R4: A connected lane with no other connected lane receives the largest magnitude (31) minus the offset, which is 30.
- R5: A connected lane's output sign is the XOR of the signs of all other connected lanes.
- R6: An output whose magnitude is 0 always carries sign 0.
- R7: A lane whose connect bit is 0 outputs all zeros. Its sign and magnitude have no effect on any other lane.
- R8: `out_valid` equals `in_valid` of the previous cycle. The output messages for an accepted row appear in that same cycle.
- R9: While `in_valid` is 0, the output messages keep their previous values.
- R10: A synchronous active-low reset clears `out_valid` and all output messages to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Row present on the inputs this cycle |
| edge_en | input | 8 | Connect mask, one bit per lane |
| v2c_msg | input | 48 | Variable-to-check messages, lane layout as R1 |
| out_valid | output | 1 | Output messages updated this cycle |
| c2v_msg | output | 48 | Check-to-variable messages, lane layout as R1 |

## Verification
The bench probes ties for the minimum. A design that leaves the tied duplicate out of the runner-up search would hand the minimum lane a larger value. It also drives lanes that are connected alone or not connected at all. Here a wrong empty-set default or a leaking disabled lane shows up as wrong magnitudes or wrong signs on the other lanes. Magnitudes of 0 and 1 with negative signs are used to expose negative zero and a missing floor at zero. Idle cycles with changing inputs catch outputs that do not hold their values or a valid flag that sits in the wrong cycle. A behavioural model, written as a plain loop over the other lanes, is compared with every lane on every clock.

// File: rtl/cn_pkg.sv
// cn_pkg: default geometry and offset for the check node processor.
// Assumes: every module of the block takes these as parameter defaults.
package cn_pkg;
    localparam int CN_EDGES_DEF  = 8;  // lanes per check row
    localparam int CN_MAG_W_DEF  = 5;  // magnitude bits per message
    localparam int CN_OFFSET_DEF = 1;  // offset in magnitude LSBs
endpackage

// File: rtl/cn_min_search.sv
// cn_min_search: finds the smallest and second-smallest magnitude among the
// connected lanes, and the lowest lane index that holds the smallest.
// Assumes: EDGES >= 2. With no connected lane both minima read all ones.
module cn_min_search #(
    parameter int EDGES = cn_pkg::CN_EDGES_DEF,
    parameter int MAG_W = cn_pkg::CN_MAG_W_DEF,
    localparam int IDX_W = $clog2(EDGES)
) (
    input  logic [EDGES*MAG_W-1:0] mag_flat,
    input  logic [EDGES-1:0]       en,
    output logic [MAG_W-1:0]       min1,
    output logic [MAG_W-1:0]       min2,
    output logic [IDX_W-1:0]       min1_idx
);
    // Linear scan: a strictly smaller value shifts min1 down into min2.
    always_comb begin
        min1     = '1;
        min2     = '1;
        min1_idx = '0;
        for (int i = 0; i < EDGES; i++) begin
            if (en[i]) begin
                if (mag_flat[i*MAG_W +: MAG_W] < min1) begin
                    min2     = min1;
                    min1     = mag_flat[i*MAG_W +: MAG_W];
                    min1_idx = IDX_W'(i);
                end else if (mag_flat[i*MAG_W +: MAG_W] < min2) begin
                    min2 = mag_flat[i*MAG_W +: MAG_W];
                end
            end
        end
    end
endmodule

// File: rtl/cn_sign_parity.sv
// cn_sign_parity: XOR of the signs of all connected lanes.
// Assumes: disconnected lanes may carry any sign and must not count.
module cn_sign_parity #(
    parameter int EDGES = cn_pkg::CN_EDGES_DEF
) (
    input  logic [EDGES-1:0] sign_vec,
    input  logic [EDGES-1:0] en,
    output logic             parity
);
    // Masked reduction XOR over the connected lanes.
    always_comb parity = ^(sign_vec & en);
endmodule

// File: rtl/cn_edge_out.sv
// cn_edge_out: forms one lane's outgoing message from the shared min pair
// and the row parity. It picks min2 for the minimum lane and min1 otherwise,
// applies a floored offset, removes the lane's own sign and suppresses
// negative zero.
// Assumes: OFFSET < 2**MAG_W; a disconnected lane is forced to zero.
module cn_edge_out #(
    parameter int MAG_W  = cn_pkg::CN_MAG_W_DEF,
    parameter int OFFSET = cn_pkg::CN_OFFSET_DEF
) (
    input  logic             en,
    input  logic             own_sign,
    input  logic             is_min,
    input  logic [MAG_W-1:0] min1,
    input  logic [MAG_W-1:0] min2,
    input  logic             parity,
    output logic [MAG_W:0]   msg
);
    localparam logic [MAG_W-1:0] OFS = MAG_W'(OFFSET);

    logic [MAG_W-1:0] sel_mag;
    logic [MAG_W-1:0] res_mag;
    logic             res_sgn;

    // Exclude the lane itself from the minimum it is given.
    always_comb sel_mag = is_min ? min2 : min1;

    // Offset subtraction, floored at zero.
    always_comb res_mag = (sel_mag > OFS) ? (sel_mag - OFS) : '0;

    // Sign of the other lanes; positive whenever the magnitude is zero.
    always_comb res_sgn = (parity ^ own_sign) & (res_mag != '0);

    // Pack the lane, or drive zero when the lane is not connected.
    always_comb msg = en ? {res_sgn, res_mag} : '0;
endmodule

// File: rtl/ms_check_node.sv
// ms_check_node: offset min-sum check node processor with one register
// stage. Lane i of each bus is {sign, magnitude} at [i*MSG_W +: MSG_W].
// Assumes: synchronous active-low reset; outputs load only on in_valid.
module ms_check_node
    import cn_pkg::*;
#(
    parameter int EDGES  = CN_EDGES_DEF,
    parameter int MAG_W  = CN_MAG_W_DEF,
    parameter int OFFSET = CN_OFFSET_DEF,
    localparam int MSG_W = MAG_W + 1,
    localparam int BUS_W = EDGES * MSG_W,
    localparam int IDX_W = $clog2(EDGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EDGES-1:0] edge_en,
    input  logic [BUS_W-1:0] v2c_msg,
    output logic             out_valid,
    output logic [BUS_W-1:0] c2v_msg
);
    localparam logic [MAG_W-1:0] MAX_MAG  = '1;
    localparam logic [MAG_W-1:0] LONE_MAG =
        (int'(MAX_MAG) > OFFSET) ? MAG_W'(int'(MAX_MAG) - OFFSET) : '0;

    logic [EDGES*MAG_W-1:0] mag_flat;
    logic [EDGES-1:0]       sign_vec;
    logic [MAG_W-1:0]       min1, min2;
    logic [IDX_W-1:0]       min1_idx;
    logic                   parity;
    logic [BUS_W-1:0]       next_msg;

    // Split each lane into its sign and magnitude fields.
    always_comb begin
        for (int i = 0; i < EDGES; i++) begin
            mag_flat[i*MAG_W +: MAG_W] = v2c_msg[i*MSG_W +: MAG_W];
            sign_vec[i]                = v2c_msg[i*MSG_W + MAG_W];
        end
    end

    cn_min_search #(.EDGES(EDGES), .MAG_W(MAG_W)) u_min (
        .mag_flat (mag_flat),
        .en       (edge_en),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx)
    );

    cn_sign_parity #(.EDGES(EDGES)) u_par (
        .sign_vec (sign_vec),
        .en       (edge_en),
        .parity   (parity)
    );

    for (genvar g = 0; g < EDGES; g++) begin : g_lane
        cn_edge_out #(.MAG_W(MAG_W), .OFFSET(OFFSET)) u_out (
            .en       (edge_en[g]),
            .own_sign (sign_vec[g]),
            .is_min   (min1_idx == IDX_W'(g)),
            .min1     (min1),
            .min2     (min2),
            .parity   (parity),
            .msg      (next_msg[g*MSG_W +: MSG_W])
        );
    end

    // Output register: valid follows input each cycle, data loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            c2v_msg   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) c2v_msg <= next_msg;
        end
    end

    // Handshake and hold checks on the output register.
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(c2v_msg));

    // Per-lane output checks.
    for (genvar g = 0; g < EDGES; g++) begin : g_chk
        p_no_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (c2v_msg[g*MSG_W +: MAG_W] == '0) |-> !c2v_msg[g*MSG_W + MAG_W]);
        p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !edge_en[g]) |=> (c2v_msg[g*MSG_W +: MSG_W] == '0));
        p_lone_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && edge_en == (EDGES'(1) << g))
            |=> (c2v_msg[g*MSG_W +: MAG_W] == LONE_MAG));
    end
endmodule

// File: tb/tb_ms_check_node.sv
// tb_ms_check_node: behavioural reference compared with every lane each clock.
// Lane layout per R1: sign at bit 6i+5, magnitude at [6i+4:6i].
module tb_ms_check_node;
    localparam int E  = 8;
    localparam int MW = 5;
    localparam int LW = MW + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [E-1:0]    edge_en = '0;
    logic [E*LW-1:0] v2c_msg = '0;
    logic            out_valid;
    logic [E*LW-1:0] c2v_msg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic            exp_valid = 1'b0;
    logic [E*LW-1:0] exp_msg = '0;
    bit              p_rst = 1'b1, p_vin = 1'b0;
    logic [E-1:0]    p_en = '0;
    logic [E*LW-1:0] p_msg = '0;

    ms_check_node dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .edge_en(edge_en),
        .v2c_msg(v2c_msg), .out_valid(out_valid), .c2v_msg(c2v_msg)
    );

    always #10 clk = ~clk;

    // Reference: loop over the other connected lanes of the row.
    function automatic logic [LW-1:0] ref_lane(input logic [E-1:0] en,
                                               input logic [E*LW-1:0] m, input int i);
        int best = (1 << MW) - 1;
        bit par = 1'b0;
        int r;
        if (!en[i]) return '0;
        for (int j = 0; j < E; j++)
            if (j != i && en[j]) begin
                if (int'(m[j*LW +: MW]) < best) best = int'(m[j*LW +: MW]);
                par ^= m[j*LW + MW];
            end
        r = (best > 1) ? best - 1 : 0;
        return {(r != 0) ? par : 1'b0, MW'(r)};
    endfunction

    function automatic logic [E*LW-1:0] mk(input int mags[E], input logic [E-1:0] sg);
        logic [E*LW-1:0] v;
        for (int i = 0; i < E; i++) v[i*LW +: LW] = {sg[i], MW'(mags[i])};
        return v;
    endfunction

    // Compare the DUT with the expectation formed from the previous drive.
    task automatic compare();
        string tag;
        n_cmp++;
        if (out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL %s out_valid: got %b expected %b",
                     p_rst ? "R10" : "R8", out_valid, exp_valid);
        end
        for (int i = 0; i < E; i++) begin
            logic [LW-1:0] g, x;
            int others, is_min;
            g = c2v_msg[i*LW +: LW];
            x = exp_msg[i*LW +: LW];
            n_cmp++;
            if (g !== x) begin
                others = 0; is_min = 1;
                for (int j = 0; j < E; j++)
                    if (j != i && p_en[j]) begin
                        others++;
                        if (p_msg[j*LW +: MW] < p_msg[i*LW +: MW]) is_min = 0;
                    end
                if (p_rst)                         tag = "R10";
                else if (!p_vin)                   tag = "R9";
                else if (!p_en[i])                 tag = "R7";
                else if (g[MW-1:0] !== x[MW-1:0])  tag = (others == 0) ? "R4" :
                                                         (is_min != 0) ? "R3" : "R2";
                else if (x[MW-1:0] == '0)          tag = "R6";
                else                               tag = "R5";
                n_bad++;
                $display("FAIL %s lane %0d: got %h expected %h", tag, i, g, x);
            end
        end
    endtask

    // One cycle: check outputs, drive new inputs, update the expectation.
    task automatic step(input bit r, input bit v, input logic [E-1:0] en,
                        input logic [E*LW-1:0] m);
        @(negedge clk);
        compare();
        rst_n = r; in_valid = v; edge_en = en; v2c_msg = m;
        p_rst = !r; p_vin = v; p_en = en; p_msg = m;
        if (!r) begin
            exp_valid = 1'b0; exp_msg = '0;
        end else begin
            exp_valid = v;
            if (v) for (int i = 0; i < E; i++) exp_msg[i*LW +: LW] = ref_lane(en, m, i);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        // R10: reset state, even with a valid row presented.
        step(1'b0, 1'b1, 8'hFF, {E*LW{1'b1}});
        step(1'b0, 1'b0, '0, '0);
        // R2, R5: all connected, distinct magnitudes, mixed signs.
        step(1'b1, 1'b1, 8'hFF, mk('{9, 4, 17, 30, 6, 12, 25, 8}, 8'b1010_0110));
        // R3: tie for the minimum.
        step(1'b1, 1'b1, 8'hFF, mk('{7, 3, 20, 3, 15, 9, 11, 31}, 8'b0001_1000));
        // R3: minimum lane receives the runner-up.
        step(1'b1, 1'b1, 8'hFF, mk('{31, 31, 31, 2, 31, 31, 5, 31}, 8'b1111_1111));
        // R4: a single connected lane.
        step(1'b1, 1'b1, 8'b0010_0000, mk('{0, 1, 2, 3, 4, 9, 6, 7}, 8'hFF));
        // R7: no connected lane at all.
        step(1'b1, 1'b1, 8'h00, mk('{1, 2, 3, 4, 5, 6, 7, 8}, 8'hFF));
        // R6: magnitudes 0 and 1 with negative signs.
        step(1'b1, 1'b1, 8'hFF, mk('{0, 1, 5, 6, 7, 8, 9, 10}, 8'hFF));
        step(1'b1, 1'b1, 8'hFF, mk('{1, 1, 5, 6, 7, 8, 9, 10}, 8'b0101_0101));
        // R7: disconnected lanes carry small values and negative signs.
        step(1'b1, 1'b1, 8'b1100_0011, mk('{12, 14, 0, 1, 0, 0, 20, 22}, 8'b0011_1101));
        // R9: idle cycles with changing inputs must not disturb the outputs.
        step(1'b1, 1'b0, 8'hFF, mk('{0, 0, 0, 0, 0, 0, 0, 0}, 8'h00));
        step(1'b1, 1'b0, 8'h0F, mk('{3, 5, 7, 9, 11, 13, 15, 17}, 8'hA5));
        // R8: back-to-back rows.
        step(1'b1, 1'b1, 8'h7E, mk('{31, 30, 29, 28, 27, 26, 25, 24}, 8'h3C));
        step(1'b1, 1'b1, 8'hFF, mk('{2, 2, 2, 2, 2, 2, 2, 2}, 8'h01));
        // Random rows, connect masks and idle gaps.
        for (int k = 0; k < 400; k++) begin
            logic [E*LW-1:0] m;
            for (int i = 0; i < E; i++) m[i*LW +: LW] = LW'($urandom);
            step(1'b1, ($urandom % 4) != 0, E'($urandom), m);
        end
        // R10: reset in the middle of traffic.
        step(1'b0, 1'b1, 8'hFF, {E*LW{1'b1}});
        step(1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b0, '0, '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule